// File: doc/BRIEF.md
# Variable refresh vertical timing controller

This block counts the vertical lines of one display pipe and decides, frame by frame, where vertical blanking ends. A `line_tick` input marks each horizontal line. In fixed-refresh mode the frame has a programmed total, and blanking starts at a programmed line. In variable-refresh mode blanking starts at the earliest legal exit line. It is then stretched line by line until software sends a push, or until the maximum-total boundary forces the exit. Either way, a guardband of exit lines follows before the counter wraps.

Software uses a small register port: a write strobe with address and data, and a combinational read-back. The timing registers are double buffered. Writes go to shadow copies, and the active copies load on the register-latch strobe. The strobe fires at the fixed blanking line, or at the first line of the variable exit. The variable-refresh enable acts only at a frame boundary. A live status bit reports the mode actually in force, so software can poll it after clearing the enable.

The sequencer has four named states:
- **ST_ACTIVE**: visible lines.
- **ST_HOLD**: stretched blanking while waiting for a push.
- **ST_EXIT**: guardband exit lines.
- **ST_FIXBLANK**: fixed-mode blanking.

Its transitions are:
- ACTIVE→HOLD, when the earliest exit line is reached with no push.
- ACTIVE→EXIT, when that line is reached with a push pending, or when it is already the latest line.
- HOLD→EXIT, on a push or on the latest line.
- EXIT→ACTIVE, the wrap after the last guardband line.
- ACTIVE→FIXBLANK, at the fixed blanking line.
- FIXBLANK→ACTIVE, the wrap after the fixed total.
- ACTIVE→ACTIVE wrap, in fixed mode when the blanking line lies beyond the total.

Top module: `vrr_vtiming_ctrl`

## Requirements
- R1: In fixed mode (control bit 0 clear) a frame lasts FTOTAL+1 lines. FTOTAL is at address 5 and FVBS at address 6. Vblank and the latch strobe begin on line FVBS. After reset FTOTAL is 9 and FVBS is 7.
- R2: In variable mode the earliest exit line is E0 = F − G. F is the effective flip line count and G the guardband. A push pending on or before line E0 makes the exit start at E0, giving a frame of F lines.
- R3: In variable mode with no push, the exit is forced at line VMAX+1−G, giving a frame of VMAX+1 lines. VMAX is at address 2.
- R4: A push written while the counter shows line p, with p at or after E0 and before the forced line, starts the exit at line p+1. The frame then lasts p+1+G lines, and the latch strobe occurs on line p+1.
- R5: VMIN (address 1), VMAX and FLIP (address 3) each hold a line count minus one. With the flip enable (control bit 1) set, F = max(FLIP+1, VMIN+2). With it clear, F = VMIN+2.
- R6: The guardband field is control bits 15:8. A guardband of 0 acts as 1.
- R7: In variable mode vblank rises on line E0 whatever the push timing. It stays high through the exit lines.
- R8: The push register is at address 4, with bit 0 enable and bit 1 send. Writing both bits set makes send read back as 1 until the push is consumed at the start of the exit, when it clears. A write with enable clear leaves send at 0 and does not shorten the frame.
- R9: The variable enable is control bit 0 at address 0. It takes effect only at a frame wrap. The status register (address 7, bit 0) and the `vrr_live` port show the mode of the current frame. After the enable is cleared they stay 1 until the next frame start.
- R10: A new VMAX written before the latch strobe does not change the current frame. It applies from the frame after that strobe.
- R11: `frame_start` and `latch_strobe` are one-cycle pulses that follow a line tick, and they are never high together.
- R12: After reset, `frame_start`, `vblank` and `vrr_live` are 0, and the push and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle pulse per horizontal line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| frame_start | output | 1 | Pulse when the line counter wraps to zero |
| vblank | output | 1 | High during vertical blanking |
| latch_strobe | output | 1 | Pulse when shadow registers move to active |
| vrr_live | output | 1 | Variable mode active in the current frame |

## Verification
The exit decision is driven with pushes at several points:
- A push well before the earliest exit line and a push one line before it both show that an early push is held, not lost.
- Pushes inside the hold window show that the frame ends one line after the push.
- A push on the line just before the forced boundary cannot be told apart from no push, and so confirms the clamp.

Further table rows vary the flip-enable bit, a flip value below VMIN+2, a zero guardband and a wide guardband, to separate the window arithmetic from the counting. Directed runs cover the double-buffer delay, push read-back, a push ignored for lack of the enable bit, and the live-status delay on disable.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_VMIN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_VMAX   = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLIP   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PUSH   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FTOTAL = 3'd5;
    localparam logic [ADDR_W-1:0] A_FVBS   = 3'd6;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd7;

    localparam int CTRL_VRR_BIT  = 0;
    localparam int CTRL_FLIP_BIT = 1;
    localparam int PUSH_EN_BIT   = 0;
    localparam int PUSH_SEND_BIT = 1;

    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_HOLD     = 2'd1,
        ST_EXIT     = 2'd2,
        ST_FIXBLANK = 2'd3
    } seq_state_t;

endpackage

// File: rtl/vrr_regs.sv
module vrr_regs
    import vrr_pkg::*;
#(
    parameter int LINE_W     = 12,
    parameter int GB_W       = 8,
    parameter int DATA_W     = 16,
    parameter int RST_FTOTAL = 9,
    parameter int RST_FVBS   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              latch_now,
    input  logic              consume_now,
    input  logic              live,
    output logic              vrr_req,
    output logic              act_flip_en,
    output logic [GB_W-1:0]   act_gb,
    output logic [LINE_W-1:0] act_vmin,
    output logic [LINE_W-1:0] act_vmax,
    output logic [LINE_W-1:0] act_flip,
    output logic [LINE_W-1:0] act_ftotal,
    output logic [LINE_W-1:0] act_fvbs,
    output logic              push_pend
);

    localparam int GB_LSB = DATA_W - GB_W;
    localparam logic [LINE_W-1:0] FT_INIT = LINE_W'(RST_FTOTAL);
    localparam logic [LINE_W-1:0] FV_INIT = LINE_W'(RST_FVBS);

    logic              sh_vrr, sh_fen;
    logic [GB_W-1:0]   sh_gb;
    logic [LINE_W-1:0] sh_vmin, sh_vmax, sh_flip, sh_ftotal, sh_fvbs;
    logic              push_en;
    logic              wr_push;
    logic [LINE_W-1:0] wr_line;

    assign wr_push = wr_en && (wr_addr == A_PUSH);
    assign wr_line = wr_data[LINE_W-1:0];

    // shadow bank, written by software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_vrr    <= 1'b0;
            sh_fen    <= 1'b0;
            sh_gb     <= '0;
            sh_vmin   <= '0;
            sh_vmax   <= '0;
            sh_flip   <= '0;
            sh_ftotal <= FT_INIT;
            sh_fvbs   <= FV_INIT;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    sh_vrr <= wr_data[CTRL_VRR_BIT];
                    sh_fen <= wr_data[CTRL_FLIP_BIT];
                    sh_gb  <= wr_data[DATA_W-1 -: GB_W];
                end
                A_VMIN:   sh_vmin   <= wr_line;
                A_VMAX:   sh_vmax   <= wr_line;
                A_FLIP:   sh_flip   <= wr_line;
                A_FTOTAL: sh_ftotal <= wr_line;
                A_FVBS:   sh_fvbs   <= wr_line;
                default: ;
            endcase
        end
    end

    // active bank, loaded on the latch strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_flip_en <= 1'b0;
            act_gb      <= '0;
            act_vmin    <= '0;
            act_vmax    <= '0;
            act_flip    <= '0;
            act_ftotal  <= FT_INIT;
            act_fvbs    <= FV_INIT;
        end else if (latch_now) begin
            act_flip_en <= sh_fen;
            act_gb      <= sh_gb;
            act_vmin    <= sh_vmin;
            act_vmax    <= sh_vmax;
            act_flip    <= sh_flip;
            act_ftotal  <= sh_ftotal;
            act_fvbs    <= sh_fvbs;
        end
    end

    // push register: a write wins over a same-cycle consumption
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_en   <= 1'b0;
            push_pend <= 1'b0;
        end else if (wr_push) begin
            push_en   <= wr_data[PUSH_EN_BIT];
            push_pend <= wr_data[PUSH_EN_BIT] & wr_data[PUSH_SEND_BIT];
        end else if (consume_now) begin
            push_pend <= 1'b0;
        end
    end

    assign vrr_req = sh_vrr;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[CTRL_VRR_BIT]      = sh_vrr;
                rd_data[CTRL_FLIP_BIT]     = sh_fen;
                rd_data[DATA_W-1 -: GB_W]  = sh_gb;
            end
            A_VMIN:   rd_data[LINE_W-1:0] = sh_vmin;
            A_VMAX:   rd_data[LINE_W-1:0] = sh_vmax;
            A_FLIP:   rd_data[LINE_W-1:0] = sh_flip;
            A_FTOTAL: rd_data[LINE_W-1:0] = sh_ftotal;
            A_FVBS:   rd_data[LINE_W-1:0] = sh_fvbs;
            A_PUSH: begin
                rd_data[PUSH_EN_BIT]   = push_en;
                rd_data[PUSH_SEND_BIT] = push_pend;
            end
            A_STATUS: rd_data[0] = live;
            default:  rd_data = '0;
        endcase
    end

    // R8: a consumed push is gone on the next cycle unless rewritten
    a_r8_push_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_now && !wr_push) |=> !push_pend);

    // R8: send is never pending without the enable bit
    a_r8_send_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        push_pend |-> push_en);

    initial begin
        a_r6_gb_fits: assert (GB_LSB >= 2);
    end

endmodule

// File: rtl/vrr_limits.sv
module vrr_limits #(
    parameter int LINE_W = 12,
    parameter int GB_W   = 8
) (
    input  logic              flip_en,
    input  logic [GB_W-1:0]   gb,
    input  logic [LINE_W-1:0] vmin_m1,
    input  logic [LINE_W-1:0] vmax_m1,
    input  logic [LINE_W-1:0] flip_m1,
    output logic [LINE_W-1:0] early,
    output logic [LINE_W-1:0] late,
    output logic [LINE_W-1:0] g_eff
);

    localparam int XW = LINE_W + 1;
    localparam logic [XW-1:0] ONE = XW'(1);

    logic [XW-1:0] flip_l, vmin_p, flip_eff, vmax_l, g_x, early_x, late_raw, late_x;

    always_comb begin
        flip_l   = {1'b0, flip_m1} + ONE;
        vmin_p   = {1'b0, vmin_m1} + XW'(2);
        if (flip_en)
            flip_eff = (flip_l > vmin_p) ? flip_l : vmin_p;
        else
            flip_eff = vmin_p;
        g_x      = (gb == '0) ? ONE : XW'(gb);
        early_x  = (flip_eff > g_x) ? (flip_eff - g_x) : ONE;
        vmax_l   = {1'b0, vmax_m1} + ONE;
        late_raw = (vmax_l > g_x) ? (vmax_l - g_x) : ONE;
        late_x   = (late_raw < early_x) ? early_x : late_raw;
    end

    // saturate into the line width
    assign early = early_x[LINE_W] ? '1 : early_x[LINE_W-1:0];
    assign late  = late_x[LINE_W]  ? '1 : late_x[LINE_W-1:0];
    assign g_eff = g_x[LINE_W]     ? '1 : g_x[LINE_W-1:0];

endmodule

// File: rtl/vrr_seq.sv
module vrr_seq
    import vrr_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              vrr_req,
    input  logic              push_pend,
    input  logic [LINE_W-1:0] early,
    input  logic [LINE_W-1:0] late,
    input  logic [LINE_W-1:0] g_eff,
    input  logic [LINE_W-1:0] ftotal,
    input  logic [LINE_W-1:0] fvbs,
    output logic              latch_now,
    output logic              consume_now,
    output logic              live,
    output logic              frame_start,
    output logic              latch_strobe,
    output logic              vblank
);

    seq_state_t        state, nxt_state;
    logic [LINE_W-1:0] lcnt, nxt_lcnt, line_nx;
    logic [LINE_W-1:0] exit_end, nxt_end;
    logic              do_wrap;

    assign line_nx = lcnt + LINE_W'(1);

    // next-state decision, evaluated on each line tick
    always_comb begin
        nxt_state = state;
        nxt_lcnt  = lcnt;
        nxt_end   = exit_end;
        do_wrap   = 1'b0;
        latch_now = 1'b0;
        if (line_tick) begin
            unique case (state)
                ST_ACTIVE: begin
                    if (live) begin
                        nxt_lcnt = line_nx;
                        if (line_nx >= early) begin
                            if (push_pend || line_nx >= late) begin
                                nxt_state = ST_EXIT;
                                nxt_end   = line_nx + g_eff - LINE_W'(1);
                                latch_now = 1'b1;
                            end else begin
                                nxt_state = ST_HOLD;
                            end
                        end
                    end else if (lcnt >= ftotal) begin
                        do_wrap = 1'b1;
                    end else begin
                        nxt_lcnt = line_nx;
                        if (line_nx >= fvbs) begin
                            nxt_state = ST_FIXBLANK;
                            latch_now = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    nxt_lcnt = line_nx;
                    if (push_pend || line_nx >= late) begin
                        nxt_state = ST_EXIT;
                        nxt_end   = line_nx + g_eff - LINE_W'(1);
                        latch_now = 1'b1;
                    end
                end
                ST_EXIT: begin
                    if (lcnt >= exit_end) do_wrap = 1'b1;
                    else                  nxt_lcnt = line_nx;
                end
                ST_FIXBLANK: begin
                    if (lcnt >= ftotal) do_wrap = 1'b1;
                    else                nxt_lcnt = line_nx;
                end
            endcase
            if (do_wrap) begin
                nxt_state = ST_ACTIVE;
                nxt_lcnt  = '0;
            end
        end
    end

    assign consume_now = latch_now && live;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_ACTIVE;
            lcnt     <= '0;
            exit_end <= '0;
            live     <= 1'b0;
        end else begin
            state    <= nxt_state;
            lcnt     <= nxt_lcnt;
            exit_end <= nxt_end;
            if (do_wrap) live <= vrr_req;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start  <= 1'b0;
            latch_strobe <= 1'b0;
        end else begin
            frame_start  <= do_wrap;
            latch_strobe <= latch_now;
        end
    end

    assign vblank = (state != ST_ACTIVE);

    // R11: pulses only follow a line tick and never coincide
    a_r11_fs_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(line_tick));
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && latch_strobe));

    // R9: the live mode changes only together with a frame start
    a_r9_live_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live) |-> frame_start);

    // R3: holding never runs past the forced exit line
    a_r3_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (lcnt < late));

    // R7: holding only happens in variable mode
    a_r7_hold_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> live);

endmodule

// File: rtl/vrr_vtiming_ctrl.sv
module vrr_vtiming_ctrl
    import vrr_pkg::*;
#(
    parameter int LINE_W     = 12,
    parameter int GB_W       = 8,
    parameter int DATA_W     = 16,
    parameter int RST_FTOTAL = 9,
    parameter int RST_FVBS   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              frame_start,
    output logic              vblank,
    output logic              latch_strobe,
    output logic              vrr_live
);

    logic              latch_now, consume_now, live, vrr_req, push_pend, act_fen;
    logic [GB_W-1:0]   act_gb;
    logic [LINE_W-1:0] act_vmin, act_vmax, act_flip, act_ftotal, act_fvbs;
    logic [LINE_W-1:0] early, late, g_eff;

    vrr_regs #(
        .LINE_W(LINE_W), .GB_W(GB_W), .DATA_W(DATA_W),
        .RST_FTOTAL(RST_FTOTAL), .RST_FVBS(RST_FVBS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .latch_now(latch_now), .consume_now(consume_now), .live(live),
        .vrr_req(vrr_req), .act_flip_en(act_fen), .act_gb(act_gb),
        .act_vmin(act_vmin), .act_vmax(act_vmax), .act_flip(act_flip),
        .act_ftotal(act_ftotal), .act_fvbs(act_fvbs), .push_pend(push_pend)
    );

    vrr_limits #(.LINE_W(LINE_W), .GB_W(GB_W)) u_limits (
        .flip_en(act_fen), .gb(act_gb),
        .vmin_m1(act_vmin), .vmax_m1(act_vmax), .flip_m1(act_flip),
        .early(early), .late(late), .g_eff(g_eff)
    );

    vrr_seq #(.LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .vrr_req(vrr_req), .push_pend(push_pend),
        .early(early), .late(late), .g_eff(g_eff),
        .ftotal(act_ftotal), .fvbs(act_fvbs),
        .latch_now(latch_now), .consume_now(consume_now), .live(live),
        .frame_start(frame_start), .latch_strobe(latch_strobe), .vblank(vblank)
    );

    assign vrr_live = live;

    // R9: the port and the status register agree with the sequencer mode
    a_r9_live_port: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_STATUS) |-> (rd_data[0] == vrr_live));

endmodule

// File: tb/vrr_vtiming_ctrl_test.sv
module vrr_vtiming_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NONE = 4095;

    typedef struct packed {
        logic        vrr;
        logic        fen;
        logic [11:0] vmin_r;
        logic [11:0] flip_r;
        logic [11:0] vmax_r;
        logic [7:0]  g;
        logic [11:0] push_at;
        logic [11:0] exp_len;
        logic [11:0] exp_latch;
        logic [11:0] exp_vbs;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 12'd19, 12'd20, 12'd29, 8'd4, 12'd3,    12'd21, 12'd17, 12'd17}, // R2 early push
        '{1'b1, 1'b1, 12'd19, 12'd20, 12'd29, 8'd4, 12'd4095, 12'd30, 12'd26, 12'd17}, // R3 forced
        '{1'b1, 1'b1, 12'd19, 12'd20, 12'd29, 8'd4, 12'd20,   12'd25, 12'd21, 12'd17}, // R4 mid push
        '{1'b1, 1'b1, 12'd19, 12'd20, 12'd29, 8'd4, 12'd25,   12'd30, 12'd26, 12'd17}, // R3 push at boundary
        '{1'b1, 1'b1, 12'd19, 12'd20, 12'd29, 8'd4, 12'd16,   12'd21, 12'd17, 12'd17}, // R2 push one before
        '{1'b1, 1'b1, 12'd19, 12'd20, 12'd29, 8'd0, 12'd3,    12'd21, 12'd20, 12'd20}, // R6 zero guardband
        '{1'b1, 1'b1, 12'd19, 12'd10, 12'd29, 8'd4, 12'd3,    12'd21, 12'd17, 12'd17}, // R5 flip clamp
        '{1'b1, 1'b1, 12'd19, 12'd25, 12'd29, 8'd4, 12'd3,    12'd26, 12'd22, 12'd22}, // R5 late flip
        '{1'b1, 1'b0, 12'd19, 12'd25, 12'd29, 8'd4, 12'd3,    12'd21, 12'd17, 12'd17}, // R5 flip disabled
        '{1'b1, 1'b1, 12'd19, 12'd20, 12'd29, 8'd8, 12'd18,   12'd27, 12'd19, 12'd13}, // R4 wide guard
        '{1'b0, 1'b1, 12'd19, 12'd20, 12'd29, 8'd4, 12'd4095, 12'd15, 12'd11, 12'd11}  // R1 fixed
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        frame_start, vblank, latch_strobe, vrr_live;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    vrr_vtiming_ctrl uut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_start(frame_start), .vblank(vblank),
        .latch_strobe(latch_strobe), .vrr_live(vrr_live)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // one line: tick for a cycle, sample at the following falling edge
    task automatic tick(output bit fs, output bit ls, output bit vb);
        @(negedge clk);
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        fs = frame_start; ls = latch_strobe; vb = vblank;
    endtask

    task automatic wait_fs(input int n);
        int seen = 0;
        for (int i = 0; i < 2000 && seen < n; i++) begin
            bit fs, ls, vb;
            tick(fs, ls, vb);
            if (fs) seen++;
        end
    endtask

    task automatic measure(input int push_at, output int len, output int lat, output int vbs);
        int ln = 0;
        len = -1; lat = -1; vbs = -1;
        for (int i = 0; i < 2000 && len < 0; i++) begin
            bit fs, ls, vb;
            if (ln == push_at) wr(3'd4, 16'h0003);
            tick(fs, ls, vb);
            ln++;
            if (ls && lat < 0) lat = ln;
            if (vb && vbs < 0) vbs = ln;
            if (fs) len = ln;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, len, lat, vbs;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 frame_start", int'(frame_start), 0);
        chk("R12 vblank", int'(vblank), 0);
        chk("R12 vrr_live", int'(vrr_live), 0);
        rd(3'd7, v); chk("R12 status", v, 0);
        rd(3'd4, v); chk("R12 push", v, 0);
        rst_n = 1'b1;

        // R1 default fixed timing
        wait_fs(1);
        measure(NONE, len, lat, vbs);
        chk("R1 default length", len, 10);
        chk("R1 default latch", lat, 7);
        chk("R1 default vblank", vbs, 7);

        // R11 pulse width
        wait_fs(1);
        @(negedge clk);
        chk("R11 frame_start one cycle", int'(frame_start), 0);

        wr(3'd5, 16'd14);
        wr(3'd6, 16'd11);

        // table walk: R1-style fixed row and variable rows
        for (int k = 0; k < NV; k++) begin
            wr(3'd1, {4'd0, VEC[k].vmin_r});
            wr(3'd2, {4'd0, VEC[k].vmax_r});
            wr(3'd3, {4'd0, VEC[k].flip_r});
            wr(3'd0, {VEC[k].g, 6'd0, VEC[k].fen, VEC[k].vrr});
            wait_fs(2);
            measure(int'(VEC[k].push_at), len, lat, vbs);
            chk($sformatf("R2 R3 R4 row %0d length", k), len, int'(VEC[k].exp_len));
            chk($sformatf("R4 R5 row %0d latch", k), lat, int'(VEC[k].exp_latch));
            chk($sformatf("R7 row %0d vblank start", k), vbs, int'(VEC[k].exp_vbs));
        end

        // base variable config
        wr(3'd1, 16'd19); wr(3'd2, 16'd29); wr(3'd3, 16'd20);
        wr(3'd0, {8'd4, 6'd0, 1'b1, 1'b1});
        wait_fs(2);

        // R10 double buffering of VMAX
        wr(3'd2, 16'd39);
        measure(NONE, len, lat, vbs);
        chk("R10 old vmax this frame", len, 30);
        measure(NONE, len, lat, vbs);
        chk("R10 new vmax next frame", len, 40);
        wr(3'd2, 16'd29);
        wait_fs(2);

        // R8 push readback and consumption
        wr(3'd4, 16'h0003);
        rd(3'd4, v); chk("R8 send pending", v, 3);
        measure(NONE, len, lat, vbs);
        chk("R8 R2 pushed length", len, 21);
        rd(3'd4, v); chk("R8 send consumed", v, 1);

        // R8 send without enable is ignored
        wr(3'd4, 16'h0002);
        rd(3'd4, v); chk("R8 no-enable send", v, 0);
        measure(NONE, len, lat, vbs);
        chk("R8 no-enable length", len, 30);

        // R9 disable handshake
        chk("R9 live before", int'(vrr_live), 1);
        wr(3'd0, 16'h0000);
        rd(3'd7, v); chk("R9 status holds", v, 1);
        wait_fs(1);
        rd(3'd7, v); chk("R9 status cleared", v, 0);
        chk("R9 live port cleared", int'(vrr_live), 0);
        measure(NONE, len, lat, vbs);
        chk("R9 R1 fixed after disable", len, 15);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule